// File: doc/BRIEF.md
# Parallel-Phase Oscillator Mixer Bank

This block mixes a wideband real sample stream to complex baseband when the samples arrive several per clock. Each clock carries a group of up to sixteen signed 12-bit samples, one per lane, with lane 1 holding the oldest sample of the group. The block makes a cosine and sine local-oscillator sample for every lane and multiplies each input sample by both. The result is one in-phase and one quadrature product per lane.

A single 32-bit phase accumulator advances by the lane count times the tuning word on every clock. Lane r adds a fixed offset of (r-1) times the tuning word, so the lanes together trace the same phase sequence as one oscillator running at the full input sample rate. The tuning word is the two's complement of the carrier frequency scaled by 2^32 over the input sample rate. For example, a word of 2^28 at 3.6 GS/s gives a 225 MHz tone with a step size near 0.84 Hz. The lane count is selectable at run time. Sine and cosine come from an internal quarter-wave table addressed by the top 10 phase bits.

Top module: `nco_mixer_bank`

## Requirements
- R1: While reset is held, and on the first clock after it, out_vld is 0 and out_i and out_q are all zero. Reset sets the accumulator and the tuning word to zero and selects the 4-lane mode.
- R2: The mode code selects the active lane count: 0 gives 4, 1 gives 8, and 2 or 3 give 16. Lanes at or beyond the active count output zero on both buses.
- R3: On every clock that does not clear it, the accumulator advances by the active lane count times the held tuning word, modulo 2^32. This happens whether or not in_vld is high.
- R4: Lane r (1-based) takes its sample from in_data bits [12(r-1) +: 12] and uses phase acc + (r-1)·tuning word, modulo 2^32.
- R5: The table index p is phase bits [31:22]. sine(p) = S(p mod 512), negated when p ≥ 512, where S(h) = floor(32764·x·(1024−x) / (1310720 − x·(1024−x))) with x = 2h+1. cosine(p) = sine((p+256) mod 1024).
- R6: Lane r drives out_i bits [26(r-1) +: 26] with sample·cosine and out_q at the same slice with sample·sine, both as signed 26-bit values.
- R7: Each lane product, and out_vld, appear exactly 3 clocks after the input cycle they belong to. out_vld equals in_vld from 3 clocks earlier.
- R8: When ld is high at a clock edge, theta_in and mode_in are captured. They apply to every lane from the next cycle on. The accumulator step at that same edge still uses the old word and mode. Without ld, both inputs are ignored.
- R9: When clr is high at a clock edge, the accumulator becomes zero and the held tuning word and mode are kept. clr and ld may act at the same edge.
- R10: No sine or cosine value leaves the range −8191..8191.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous accumulator clear |
| ld | input | 1 | Capture strobe for tuning word and mode |
| theta_in | input | 32 | Signed frequency tuning word |
| mode_in | input | 2 | Lane-count code (0:4, 1:8, 2/3:16) |
| in_vld | input | 1 | Input group valid |
| in_data | input | 192 | Sixteen signed 12-bit samples, lane 1 lowest |
| out_vld | output | 1 | Output group valid |
| out_i | output | 416 | Sixteen signed 26-bit in-phase products |
| out_q | output | 416 | Sixteen signed 26-bit quadrature products |

## Verification
The bench builds the block with its defaults: sixteen lanes, 12-bit samples and the 10-bit table index. At those values every mode code can be exercised, including the reserved code that aliases to 16 lanes. Idle lanes in the 4- and 8-lane modes can also be checked for zero output. Tuning words of 2^28, 2^30, 2^31 and negative values put the lane phases on exact quadrant boundaries, where the table folding is most error-prone. Full-scale samples of −2048 and 2047 stress the product width.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;
  localparam int PH_W    = 32;
  localparam int IDX_W   = 10;
  localparam int QIDX_W  = IDX_W - 2;
  localparam int Q_N     = 1 << QIDX_W;
  localparam int AMP_W   = 14;
  localparam int AMP_MAX = (1 << (AMP_W - 1)) - 1;
  localparam longint HALF = longint'(1) << IDX_W;

  // active lane count for a mode code, limited to the lanes that exist
  function automatic int lanes_of(input logic [1:0] m, input int cap);
    int n;
    case (m)
      2'd0:    n = 4;
      2'd1:    n = 8;
      default: n = 16;
    endcase
    return (n > cap) ? cap : n;
  endfunction

  function automatic logic [PH_W-1:0] stride_of(input logic [PH_W-1:0] th,
                                                input logic [1:0] m, input int cap);
    return th * PH_W'(lanes_of(m, cap));
  endfunction

  // rational sine approximation sampled at half-step centres of the first quadrant
  function automatic logic signed [AMP_W-1:0] quarter_val(input int k);
    longint x, w, num, den;
    x   = 2 * longint'(k) + 1;
    w   = x * (HALF - x);
    num = 4 * longint'(AMP_MAX) * w;
    den = (5 * HALF * HALF) / 4 - w;
    return AMP_W'(num / den);
  endfunction

  // quadrant folding: a = table at pos, b = table at mirrored pos
  function automatic logic signed [AMP_W-1:0] fold(input logic [1:0] q,
      input logic signed [AMP_W-1:0] a, input logic signed [AMP_W-1:0] b);
    case (q)
      2'd0:    return a;
      2'd1:    return b;
      2'd2:    return -a;
      default: return -b;
    endcase
  endfunction
endpackage

// File: rtl/nco_phase_gen.sv
module nco_phase_gen
  import nco_mix_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   ld,
  input  logic [PH_W-1:0]        theta_in,
  input  logic [1:0]             mode_in,
  output logic [PH_W-1:0]        acc_q,
  output logic [PH_W-1:0]        theta_q,
  output logic [PH_W-1:0]        stride,
  output logic [LANES*IDX_W-1:0] lane_idx,
  output logic [LANES-1:0]       lane_en
);
  logic [1:0] mode_q;

  assign stride = stride_of(theta_q, mode_q, LANES);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      theta_q <= '0;
      mode_q  <= 2'd0;
    end else begin
      acc_q <= clr ? '0 : acc_q + stride;
      if (ld) begin
        theta_q <= theta_in;
        mode_q  <= mode_in;
      end
    end
  end

  for (genvar r = 0; r < LANES; r++) begin : g_lane
    assign lane_idx[r*IDX_W +: IDX_W] =
      IDX_W'((acc_q + theta_q * PH_W'(r)) >> (PH_W - IDX_W));
    assign lane_en[r] = (r < lanes_of(mode_q, LANES));
  end
endmodule

// File: rtl/nco_sincos.sv
module nco_sincos
  import nco_mix_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES*IDX_W-1:0] idx,
  output logic [LANES*AMP_W-1:0] sin_q,
  output logic [LANES*AMP_W-1:0] cos_q
);
  logic signed [AMP_W-1:0] qrom [Q_N];

  for (genvar k = 0; k < Q_N; k++) begin : g_rom
    assign qrom[k] = quarter_val(k);
  end

  for (genvar r = 0; r < LANES; r++) begin : g_lane
    logic [1:0]              quad;
    logic [QIDX_W-1:0]       pos;
    logic signed [AMP_W-1:0] up, dn;

    assign quad = idx[r*IDX_W + QIDX_W +: 2];
    assign pos  = idx[r*IDX_W +: QIDX_W];
    assign up   = qrom[pos];
    assign dn   = qrom[~pos];

    always_ff @(posedge clk) begin
      if (rst) begin
        sin_q[r*AMP_W +: AMP_W] <= '0;
        cos_q[r*AMP_W +: AMP_W] <= '0;
      end else begin
        sin_q[r*AMP_W +: AMP_W] <= fold(quad, up, dn);
        cos_q[r*AMP_W +: AMP_W] <= fold(quad + 2'd1, up, dn);
      end
    end
  end
endmodule

// File: rtl/nco_lane_mix.sv
module nco_lane_mix
  import nco_mix_pkg::*;
#(
  parameter int DW = 12,
  localparam int PW = DW + AMP_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] x,
  input  logic signed [AMP_W-1:0] c,
  input  logic signed [AMP_W-1:0] s,
  output logic signed [PW-1:0] i_o,
  output logic signed [PW-1:0] q_o
);
  logic signed [PW-1:0] pi, pq;

  assign pi = x * c;
  assign pq = x * s;

  always_ff @(posedge clk) begin
    if (rst) begin
      i_o <= '0;
      q_o <= '0;
    end else begin
      i_o <= en ? pi : '0;
      q_o <= en ? pq : '0;
    end
  end
endmodule

// File: rtl/nco_mixer_bank.sv
module nco_mixer_bank
  import nco_mix_pkg::*;
#(
  parameter int LANES = 16,
  parameter int DW = 12,
  localparam int PW = DW + AMP_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                ld,
  input  logic [PH_W-1:0]     theta_in,
  input  logic [1:0]          mode_in,
  input  logic                in_vld,
  input  logic [LANES*DW-1:0] in_data,
  output logic                out_vld,
  output logic [LANES*PW-1:0] out_i,
  output logic [LANES*PW-1:0] out_q
);
  logic [PH_W-1:0]        acc_q, theta_q, stride;
  logic [LANES*IDX_W-1:0] lane_idx, idx1;
  logic [LANES-1:0]       lane_en, en1, en2;
  logic [LANES*DW-1:0]    x1, x2;
  logic                   v1, v2;
  logic [LANES*AMP_W-1:0] sin2, cos2;

  nco_phase_gen #(.LANES(LANES)) u_phase (
    .clk(clk), .rst(rst), .clr(clr), .ld(ld),
    .theta_in(theta_in), .mode_in(mode_in),
    .acc_q(acc_q), .theta_q(theta_q), .stride(stride),
    .lane_idx(lane_idx), .lane_en(lane_en)
  );

  // stage 1: table index and sample alignment
  always_ff @(posedge clk) begin
    if (rst) begin
      idx1 <= '0; x1 <= '0; en1 <= '0; v1 <= 1'b0;
    end else begin
      idx1 <= lane_idx; x1 <= in_data; en1 <= lane_en; v1 <= in_vld;
    end
  end

  // stage 2: sine and cosine lookup
  nco_sincos #(.LANES(LANES)) u_trig (
    .clk(clk), .rst(rst), .idx(idx1), .sin_q(sin2), .cos_q(cos2)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      x2 <= '0; en2 <= '0; v2 <= 1'b0; out_vld <= 1'b0;
    end else begin
      x2 <= x1; en2 <= en1; v2 <= v1; out_vld <= v2;
    end
  end

  // stage 3: per-lane products
  for (genvar r = 0; r < LANES; r++) begin : g_mix
    nco_lane_mix #(.DW(DW)) u_mix (
      .clk(clk), .rst(rst), .en(en2[r]),
      .x(x2[r*DW +: DW]),
      .c(cos2[r*AMP_W +: AMP_W]),
      .s(sin2[r*AMP_W +: AMP_W]),
      .i_o(out_i[r*PW +: PW]),
      .q_o(out_q[r*PW +: PW])
    );
  end
endmodule

// File: rtl/nco_mixer_chk.sv
module nco_mixer_chk
  import nco_mix_pkg::*;
#(
  parameter int LANES = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   clr,
  input logic                   ld,
  input logic [PH_W-1:0]        theta_in,
  input logic                   in_vld,
  input logic                   out_vld,
  input logic [PH_W-1:0]        acc_q,
  input logic [PH_W-1:0]        stride,
  input logic [PH_W-1:0]        theta_q,
  input logic [LANES*AMP_W-1:0] sin_w,
  input logic [LANES*AMP_W-1:0] cos_w
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_vld_latency_R7: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (out_vld == $past(in_vld, 3)));

  assert_acc_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc_q == '0));

  assert_acc_step_R3: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (acc_q == $past(acc_q) + $past(stride)));

  assert_word_capture_R8: assert property (@(posedge clk) disable iff (rst)
    ld |=> (theta_q == $past(theta_in)));

  assert_word_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(theta_q));

  for (genvar r = 0; r < LANES; r++) begin : g_amp
    assert_amp_bound_R10: assert property (@(posedge clk) disable iff (rst)
      ($signed(sin_w[r*AMP_W +: AMP_W]) >= -AMP_MAX) &&
      ($signed(sin_w[r*AMP_W +: AMP_W]) <=  AMP_MAX) &&
      ($signed(cos_w[r*AMP_W +: AMP_W]) >= -AMP_MAX) &&
      ($signed(cos_w[r*AMP_W +: AMP_W]) <=  AMP_MAX));
  end
endmodule

bind nco_mixer_bank nco_mixer_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .ld(ld), .theta_in(theta_in),
  .in_vld(in_vld), .out_vld(out_vld), .acc_q(acc_q), .stride(stride),
  .theta_q(theta_q), .sin_w(sin2), .cos_w(cos2)
);

// File: tb/tb_nco_mixer_bank.sv
module tb_nco_mixer_bank;
  localparam int LN = 16;
  localparam int XW = 12;
  localparam int OW = 26;
  localparam int NV = 8;

  localparam logic [31:0] V_TH [NV] = '{32'h1000_0000, 32'h0000_0001, 32'hF000_0000,
    32'h1234_5679, 32'h4000_0000, 32'h0BAD_CAFE, 32'h8000_0000, 32'hFFFF_FC01};
  localparam int V_MODE [NV] = '{1, 0, 2, 1, 0, 3, 2, 0};
  localparam int V_SEED [NV] = '{0, 3, 7, 11, 0, 5, 9, 13};

  logic clk = 1'b0;
  logic rst, clr, ld, in_vld;
  logic [31:0] theta_in;
  logic [1:0] mode_in;
  logic [LN*XW-1:0] in_data;
  logic out_vld;
  logic [LN*OW-1:0] out_i, out_q;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  nco_mixer_bank dut (
    .clk(clk), .rst(rst), .clr(clr), .ld(ld), .theta_in(theta_in),
    .mode_in(mode_in), .in_vld(in_vld), .in_data(in_data),
    .out_vld(out_vld), .out_i(out_i), .out_q(out_q)
  );

  // full-circle sine from the half-circle rational form
  function automatic int ref_sine(input int p);
    int h;
    longint x, w, v;
    h = p % 512;
    x = 2 * h + 1;
    w = x * (1024 - x);
    v = (32764 * w) / (1310720 - w);
    return (p >= 512) ? -int'(v) : int'(v);
  endfunction

  function automatic int n_of(input int m);
    return (m == 0) ? 4 : (m == 1) ? 8 : 16;
  endfunction

  function automatic int lane_x(input int seed, input int r);
    if (seed == 0) return (r % 2 == 0) ? -2048 : 2047;
    return ((seed * 37 + r * 611 + 5) % 4096) - 2048;
  endfunction

  function automatic logic [LN*OW-1:0] exp_bus(input logic [31:0] base,
      input logic [31:0] th, input int nact, input int seed, input bit want_q);
    logic [LN*OW-1:0] e;
    logic [31:0] ph;
    int p, v;
    e = '0;
    for (int r = 0; r < LN; r++) begin
      if (r < nact) begin
        ph = base + th * 32'(r);
        p  = int'(ph >> 22);
        v  = lane_x(seed, r) * (want_q ? ref_sine(p) : ref_sine((p + 256) % 1024));
        e[r*OW +: OW] = OW'(v);
      end
    end
    return e;
  endfunction

  task automatic pack_in(input int seed);
    for (int r = 0; r < LN; r++) in_data[r*XW +: XW] = XW'(lane_x(seed, r));
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk_bus(input string tag, input logic [LN*OW-1:0] act,
                         input logic [LN*OW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_cycle(input string tag, input logic [31:0] base,
      input logic [31:0] th, input int nact, input int seed);
    chk_bit({tag, " valid"}, out_vld, 1'b1);
    chk_bus({tag, " I"}, out_i, exp_bus(base, th, nact, seed, 1'b0));
    chk_bus({tag, " Q"}, out_q, exp_bus(base, th, nact, seed, 1'b1));
  endtask

  // clear and load together, then stream one group for several clocks
  task automatic run_vec(input logic [31:0] th, input int m, input int seed);
    clr = 1'b1; ld = 1'b1; theta_in = th; mode_in = 2'(m); in_vld = 1'b0;
    tick;
    clr = 1'b0; ld = 1'b0; in_vld = 1'b1; pack_in(seed);
    for (int j = 1; j <= 6; j++) begin
      tick;
      if (j >= 3)
        check_cycle("R2/R3/R4/R5/R6/R10 vector", 32'((j - 3) * n_of(m)) * th, th, n_of(m), seed);
    end
    in_vld = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; clr = 1'b0; ld = 1'b0; in_vld = 1'b1;
    theta_in = 32'hDEAD_BEEF; mode_in = 2'd2; pack_in(4);
    repeat (3) tick;
    // R1: outputs idle during reset
    chk_bit("R1 reset valid", out_vld, 1'b0);
    chk_bus("R1 reset I", out_i, '0);
    chk_bus("R1 reset Q", out_q, '0);
    rst = 1'b0;
    for (int j = 1; j <= 4; j++) begin
      tick;
      if (j >= 3) check_cycle("R1 zero word, 4 lanes", 32'h0, 32'h0, 4, 4);
    end
    in_vld = 1'b0;

    for (int v = 0; v < NV; v++) run_vec(V_TH[v], V_MODE[v], V_SEED[v]);

    // R8: load without clear; old stride applies at the load edge
    clr = 1'b1; ld = 1'b1; theta_in = 32'h0100_0000; mode_in = 2'd0;
    tick;
    clr = 1'b0; ld = 1'b1; theta_in = 32'h0300_0000; mode_in = 2'd1;
    in_vld = 1'b1; pack_in(2);
    tick;
    ld = 1'b0; theta_in = 32'h7777_7777; mode_in = 2'd2;
    tick;
    tick;
    check_cycle("R8 before load", 32'h0, 32'h0100_0000, 4, 2);
    tick;
    check_cycle("R8 first loaded cycle", 32'h0400_0000, 32'h0300_0000, 8, 2);
    tick;
    check_cycle("R8 second loaded cycle", 32'h0400_0000 + 32'h1800_0000, 32'h0300_0000, 8, 2);

    // R9: clear alone keeps the word and mode; theta_in ignored without ld
    clr = 1'b1; theta_in = 32'h5555_0000; mode_in = 2'd0;
    tick;
    clr = 1'b0;
    for (int j = 1; j <= 4; j++) begin
      tick;
      if (j >= 3)
        check_cycle("R9 clear keeps word", 32'((j - 3) * 8) * 32'h0300_0000, 32'h0300_0000, 8, 2);
    end

    // R7: a gap in the input valid appears 3 clocks later
    in_vld = 1'b0;
    tick;
    in_vld = 1'b1;
    tick;
    tick;
    chk_bit("R7 gap propagated", out_vld, 1'b0);
    tick;
    chk_bit("R7 valid resumes", out_vld, 1'b1);
    in_vld = 1'b0;
    repeat (4) tick;
    chk_bit("R7 idle after stream", out_vld, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule